// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two byte-wide ports, A and B, and passes data between them in either direction without inversion. Each direction owns a storage register with its own capture strobe: the A-to-B register takes the value seen on port A, and the B-to-A register takes the value seen on port B. A per-direction select decides whether the driven port carries the live value from the other side or the value held in that direction's register. This lets a bus snapshot be replayed later, or sent straight through.

An active-low enable and a direction input pick the port that is driven, if any. While the enable is high, both ports are isolated, but both registers can still capture. Each port appears as separate input, output and output-enable signals, so a pad ring or a tri-state wrapper can build the physical bidirectional bus. The capture strobes are level signals sampled on the system clock. A register loads on the clock edge at which its strobe is first seen high.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A synchronous active-high reset clears both storage registers to zero, which shows on a driven port whose select is 1 (held).
- R2: While `oe_n_i` is 1, both `a_oe_o` and `b_oe_o` are 0.
- R3: While `oe_n_i` is 0, `dir_i`=1 drives port B (`b_oe_o`=1, `a_oe_o`=0) and `dir_i`=0 drives port A (`a_oe_o`=1, `b_oe_o`=0).
- R4: With port B driven and `sel_ab_i`=0 (live), `b_out_o` equals `a_in_i` in the same cycle, bit for bit.
- R5: With port B driven and `sel_ab_i`=1 (held), `b_out_o` equals the A-to-B register.
- R6: With port A driven, `a_out_o` equals `b_in_i` when `sel_ba_i`=0 and equals the B-to-A register when `sel_ba_i`=1.
- R7: On the first clock edge at which `cap_ab_i` is seen high after being low, the A-to-B register loads the port A value. The new value is visible after that edge. Holding the strobe high for more cycles causes no further loads.
- R8: `cap_ba_i` loads the B-to-A register from the port B value, with the same edge rule as R7.
- R9: Captures work while both ports are isolated. The port value is then the input (`a_in_i` or `b_in_i`).
- R10: If a register's source port is being driven by the block, a capture takes the driven value (`a_out_o` or `b_out_o`), not the input.
- R11: `a_oe_o` and `b_oe_o` are never 1 together.
- R12: Both registers can capture on the same edge, independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| oe_n_i | input | 1 | Active-low output enable |
| dir_i | input | 1 | 1: drive port B, 0: drive port A |
| sel_ab_i | input | 1 | Port B source: 0 live A, 1 held A-to-B register |
| sel_ba_i | input | 1 | Port A source: 0 live B, 1 held B-to-A register |
| cap_ab_i | input | 1 | Capture strobe for the A-to-B register |
| cap_ba_i | input | 1 | Capture strobe for the B-to-A register |
| a_in_i | input | WIDTH | Value present on port A from outside |
| a_out_o | output | WIDTH | Value driven onto port A (zero when not driven) |
| a_oe_o | output | 1 | Port A driver enable |
| b_in_i | input | WIDTH | Value present on port B from outside |
| b_out_o | output | WIDTH | Value driven onto port B (zero when not driven) |
| b_oe_o | output | 1 | Port B driver enable |

## Verification
Two functions can meet in one cycle. In the first case, a register captures while the same register is also routed to the driven port through the held select. In the second case, both registers capture on the same edge while one of them takes its value from the port the block itself is driving. The bench provokes both cases by raising the strobes during every mix of enable, direction and selects, including a capture on port A while port A replays the B-to-A register. A reference model in the bench predicts the port values before each edge and the register contents after it. Each output is judged on the falling edge, where the old value must still show before the edge and the new value after it.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Source choice for a driven port
  typedef enum logic {
    SEL_LIVE = 1'b0,
    SEL_HELD = 1'b1
  } sel_e;

  // Which port the block drives when enabled
  typedef enum logic {
    TOWARD_A = 1'b0,
    TOWARD_B = 1'b1
  } dir_e;

  typedef struct packed {
    logic a_en;
    logic b_en;
  } drive_t;

endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int WIDTH        = 8,
  parameter bit EDGE_CAPTURE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             strobe_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic take;

  generate
    if (EDGE_CAPTURE) begin : g_edge
      logic strobe_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) strobe_q <= 1'b0;
        else       strobe_q <= strobe_i;
      end
      assign take = strobe_i & ~strobe_q;

      // R7
      single_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(strobe_i) && strobe_i) |=> $stable(q_o));
    end else begin : g_level
      assign take = strobe_i;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i)     q_o <= '0;
    else if (take) q_o <= d_i;
  end

  // R7
  load_value_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    take |=> (q_o == $past(d_i)));

  // R8
  hold_value_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !take |=> $stable(q_o));

endmodule

// File: rtl/xcvr_steer.sv
module xcvr_steer
  import xcvr_pkg::*;
(
  input  logic   oe_n_i,
  input  dir_e   dir_i,
  output drive_t drv_o
);

  always_comb begin
    drv_o = '0;
    if (!oe_n_i) begin
      if (dir_i == TOWARD_B) drv_o.b_en = 1'b1;
      else                   drv_o.a_en = 1'b1;
    end
  end

endmodule

// File: rtl/xcvr_select.sv
module xcvr_select
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             en_i,
  input  sel_e             sel_i,
  input  logic [WIDTH-1:0] live_i,
  input  logic [WIDTH-1:0] held_i,
  output logic [WIDTH-1:0] y_o
);

  always_comb begin
    y_o = '0;
    if (en_i) y_o = (sel_i == SEL_HELD) ? held_i : live_i;
  end

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter bit EDGE_CAPTURE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             oe_n_i,
  input  logic             dir_i,
  input  logic             sel_ab_i,
  input  logic             sel_ba_i,
  input  logic             cap_ab_i,
  input  logic             cap_ba_i,
  input  logic [WIDTH-1:0] a_in_i,
  output logic [WIDTH-1:0] a_out_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_in_i,
  output logic [WIDTH-1:0] b_out_o,
  output logic             b_oe_o
);

  drive_t           drv;
  logic [WIDTH-1:0] held_ab;
  logic [WIDTH-1:0] held_ba;
  logic [WIDTH-1:0] a_port;
  logic [WIDTH-1:0] b_port;

  xcvr_steer u_steer (
    .oe_n_i (oe_n_i),
    .dir_i  (dir_e'(dir_i)),
    .drv_o  (drv)
  );

  // Port B is fed from live A or the A-to-B register
  xcvr_select #(.WIDTH(WIDTH)) u_sel_b (
    .en_i   (drv.b_en),
    .sel_i  (sel_e'(sel_ab_i)),
    .live_i (a_in_i),
    .held_i (held_ab),
    .y_o    (b_out_o)
  );

  // Port A is fed from live B or the B-to-A register
  xcvr_select #(.WIDTH(WIDTH)) u_sel_a (
    .en_i   (drv.a_en),
    .sel_i  (sel_e'(sel_ba_i)),
    .live_i (b_in_i),
    .held_i (held_ba),
    .y_o    (a_out_o)
  );

  assign a_oe_o = drv.a_en;
  assign b_oe_o = drv.b_en;

  // The wire value of each port: the block's own drive when enabled
  assign a_port = drv.a_en ? a_out_o : a_in_i;
  assign b_port = drv.b_en ? b_out_o : b_in_i;

  xcvr_capture #(.WIDTH(WIDTH), .EDGE_CAPTURE(EDGE_CAPTURE)) u_reg_ab (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .strobe_i (cap_ab_i),
    .d_i      (a_port),
    .q_o      (held_ab)
  );

  xcvr_capture #(.WIDTH(WIDTH), .EDGE_CAPTURE(EDGE_CAPTURE)) u_reg_ba (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .strobe_i (cap_ba_i),
    .d_i      (b_port),
    .q_o      (held_ba)
  );

  // R11
  one_driver_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(a_oe_o && b_oe_o));

  // R2
  isolate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    oe_n_i |-> (!a_oe_o && !b_oe_o));

  // R4
  live_b_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (b_oe_o && !sel_ab_i) |-> (b_out_o == a_in_i));

  // R5
  held_b_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (b_oe_o && sel_ab_i) |-> (b_out_o == held_ab));

  // R6
  live_a_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (a_oe_o && !sel_ba_i) |-> (a_out_o == b_in_i));

endmodule

// File: tb/tb_bus_xcvr_reg.sv
`timescale 1ns/1ps
module tb_bus_xcvr_reg;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         oe_n, dir, sel_ab, sel_ba, cap_ab, cap_ba;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  always #4 clk = ~clk; // 125 MHz

  bus_xcvr_reg #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_i(rst), .oe_n_i(oe_n), .dir_i(dir),
    .sel_ab_i(sel_ab), .sel_ba_i(sel_ba), .cap_ab_i(cap_ab), .cap_ba_i(cap_ba),
    .a_in_i(a_in), .a_out_o(a_out), .a_oe_o(a_oe),
    .b_in_i(b_in), .b_out_o(b_out), .b_oe_o(b_oe)
  );

  typedef struct {
    logic         a_oe;
    logic         b_oe;
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  logic [W-1:0] m_ab, m_ba;
  logic         m_pab, m_pba;

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, predict, advance model
  task automatic step(input logic oe, input logic d, input logic sab, input logic sba,
                      input logic [W-1:0] ain, input logic [W-1:0] bin,
                      input logic cab, input logic cba, input string tag);
    exp_t         e;
    logic [W-1:0] a_val, b_val;
    @(negedge clk);
    oe_n = oe; dir = d; sel_ab = sab; sel_ba = sba;
    a_in = ain; b_in = bin; cap_ab = cab; cap_ba = cba;
    e.a_oe  = !oe && !d;
    e.b_oe  = !oe && d;
    e.a_out = e.a_oe ? (sba ? m_ba : bin) : '0;
    e.b_out = e.b_oe ? (sab ? m_ab : ain) : '0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    a_val = e.a_oe ? e.a_out : ain;
    b_val = e.b_oe ? e.b_out : bin;
    if (cab && !m_pab) m_ab = a_val;
    if (cba && !m_pba) m_ba = b_val;
    m_pab = cab;
    m_pba = cba;
  endtask

  // monitor: compare each predicted item after the outputs settle
  always @(negedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, "a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, e.a_oe});
      check(t, "b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, e.b_oe});
      if (e.a_oe) check(t, "a_out", a_out, e.a_out);
      if (e.b_oe) check(t, "b_out", b_out, e.b_out);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; oe_n = 1'b1; dir = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0;
    cap_ab = 1'b0; cap_ba = 1'b0; a_in = 8'hEE; b_in = 8'h77;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_ab = '0; m_ba = '0; m_pab = 1'b0; m_pba = 1'b0;

    // R1: held values are zero after reset
    step(0, 1, 1, 0, 8'h11, 8'h22, 0, 0, "R1 ab");
    step(0, 0, 0, 1, 8'h11, 8'h22, 0, 0, "R1 ba");

    // R2 R3 R4 R5 R6 R11: every enable/direction/select mix
    for (int k = 0; k < 16; k++) begin
      step(k[3], k[2], k[1], k[0], 8'h5A ^ 8'(k), 8'hA5 + 8'(k), 0, 0, "R2_R3_R4_R5_R6_R11");
    end

    // R9 R12: isolated, both registers load on one edge
    step(1, 0, 0, 0, 8'h3C, 8'hC3, 1, 1, "R9_R12 cap");
    step(0, 1, 1, 0, 8'h00, 8'h00, 0, 0, "R9 ab");
    step(0, 0, 0, 1, 8'h00, 8'h00, 0, 0, "R9 ba");

    // R7: held high strobe loads only once
    step(1, 0, 0, 0, 8'h81, 8'h00, 1, 0, "R7 first");
    step(1, 0, 0, 0, 8'h42, 8'h00, 1, 0, "R7 hold");
    step(1, 0, 0, 0, 8'h24, 8'h00, 1, 0, "R7 hold");
    step(0, 1, 1, 0, 8'h99, 8'h00, 0, 0, "R7 read");

    // R8: B-to-A load while port A is driven live, B is the input
    step(0, 0, 0, 0, 8'h10, 8'hF0, 0, 1, "R8 cap");
    step(0, 0, 0, 1, 8'h10, 8'h0F, 0, 0, "R8 read");

    // R10: port A replays B-to-A register while A-to-B captures from A
    step(0, 0, 0, 1, 8'hDD, 8'h66, 1, 0, "R10 drvA");
    step(0, 1, 1, 0, 8'h00, 8'h00, 0, 0, "R10 readA");
    // R10 R12: B driven held, capture both; B-to-A takes driven B value
    step(0, 1, 1, 0, 8'h77, 8'h12, 1, 1, "R10_R12 drvB");
    step(0, 1, 1, 0, 8'h00, 8'h00, 0, 0, "R10 readAB");
    step(0, 0, 0, 1, 8'h00, 8'h00, 0, 0, "R10 readBA");

    // capture vs held select in the same cycle, all mixes
    for (int k = 0; k < 16; k++) begin
      step(k[3], k[2], k[1], k[0], 8'h1F * 8'(k + 1), 8'hE3 ^ 8'(k * 7), k[0], k[1], "R5_R6_R7_R8_R12 mix");
      step(k[3], k[2], k[1], k[0], 8'h00, 8'hFF, 0, 0, "R5_R6 mix read");
    end

    step(1, 0, 0, 0, 8'h00, 8'h00, 0, 0, "R2 end");
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule